// File: doc/BRIEF.md
# Protected Programmable Main-Clock Divider

This block derives a slower tick from the main clock. Software selects the division ratio through an 8-bit register whose low five bits hold a sparse select code. Only ten code values are legal, and they give ratios of 1, 2, 3, 4, 6, 8, 10, 12, 14 and 16. The output is a clock-enable: it is a one-cycle pulse every N main-clock cycles, and for a ratio of 1 it stays high all the time. Downstream logic uses this pulse to gate its register updates.

The register is guarded in three ways. A write is accepted only while a separate unlock input is high. Writes are also refused while the double-speed flag is set. A write that carries an illegal code is dropped, and the block reports it on a one-cycle error output. A pulse on the low-power entry input forces the select code back to the divide-by-8 value, unless the on-chip-oscillator mode flag is high. A new ratio takes effect only when the divided period in progress has finished, so no output period is ever cut short.

Top module: `mclk_divider`

## Requirements
- R1: After reset, rd_data reads 8'h08 (select code 01000b) and the divider runs at divide-by-8.
- R2: The select codes map to ratios as follows: 00000b gives 16, 00010b gives 2, 00011b gives 3, 00100b gives 4, 00110b gives 6, 01000b gives 8, 01010b gives 10, 01100b gives 12, 01110b gives 14, and 10010b gives 1. The stored code is always one of these ten.
- R3: clk_en is a single-cycle pulse once every N clock cycles, where N is the active ratio. When N is 1, clk_en is high on every cycle.
- R4: A write (wr_en high with a code in wr_data[4:0]) changes the register only if wr_unlock is high. With wr_unlock low, the register keeps its value.
- R5: While dbl_speed is high, every write is ignored and the register keeps its value.
- R6: An otherwise accepted write with an illegal code leaves the register unchanged. It raises code_err for exactly one cycle, in the cycle that follows the write. A legal write or a refused write leaves code_err low.
- R7: A cycle with lp_entry high and osc_mode low loads select code 01000b into the register.
- R8: With osc_mode high, lp_entry has no effect on the register.
- R9: A new ratio is applied only at the end of the divided period in progress. The period that is running when the write lands keeps its old length.
- R10: rd_data[7:5] always read 0, and wr_data[7:5] have no effect.
- R11: When a forced reload (R7) and an accepted write fall in the same cycle, the reload wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; the select code is in bits 4:0 |
| wr_unlock | input | 1 | Write permission; writes pass only while it is high |
| lp_entry | input | 1 | Stop or low-power entry pulse |
| osc_mode | input | 1 | On-chip oscillator mode; exempts the register from the forced reload |
| dbl_speed | input | 1 | Double-speed mode; freezes the register |
| clk_en | output | 1 | Divided clock-enable pulse |
| rd_data | output | 8 | Register readback |
| code_err | output | 1 | One-cycle flag for a rejected illegal code |

## Verification
The assertions check on every cycle that the stored code is legal, that the reserved bits read zero, and that the register stays frozen whenever the unlock or double-speed guard refuses a write. They also check that a forced reload lands on the divide-by-8 code, that the error flag appears only after an accepted write, and that the gap between enables never exceeds sixteen cycles. Other behaviour can only be shown by the bench scenarios. These are the exact pulse count for each of the ten ratios, the constant enable at ratio 1, the full-length old period after a ratio change, the exemption in oscillator mode, and the priority of the reload over a write in the same cycle.

// File: rtl/mclk_divider.sv
module mclk_divider #(
  parameter logic [4:0] RESET_CODE = 5'b01000,
  parameter logic [4:0] LP_CODE    = 5'b01000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wr_unlock,
  input  logic       lp_entry,
  input  logic       osc_mode,
  input  logic       dbl_speed,
  output logic       clk_en,
  output logic [7:0] rd_data,
  output logic       code_err
);
  localparam int CW = 4;

  // returns {legal, ratio-1}
  function automatic logic [CW:0] decode(input logic [4:0] c);
    case (c)
      5'b10010: decode = {1'b1, 4'd0};
      5'b00010: decode = {1'b1, 4'd1};
      5'b00011: decode = {1'b1, 4'd2};
      5'b00100: decode = {1'b1, 4'd3};
      5'b00110: decode = {1'b1, 4'd5};
      5'b01000: decode = {1'b1, 4'd7};
      5'b01010: decode = {1'b1, 4'd9};
      5'b01100: decode = {1'b1, 4'd11};
      5'b01110: decode = {1'b1, 4'd13};
      5'b00000: decode = {1'b1, 4'd15};
      default:  decode = {1'b0, 4'd0};
    endcase
  endfunction

  localparam logic [CW:0] RESET_DEC = decode(RESET_CODE);

  logic [4:0]    sel;
  logic [CW-1:0] term, cnt;
  logic [CW:0]   wr_dec, sel_dec;

  wire force_lp = lp_entry & ~osc_mode;
  wire wr_ok    = wr_en & wr_unlock & ~dbl_speed;

  assign wr_dec  = decode(wr_data[4:0]);
  assign sel_dec = decode(sel);
  assign clk_en  = (cnt == term);
  assign rd_data = {3'b000, sel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel      <= RESET_CODE;
      code_err <= 1'b0;
    end else begin
      code_err <= wr_ok & ~wr_dec[CW];
      if (force_lp)
        sel <= LP_CODE;
      else if (wr_ok && wr_dec[CW])
        sel <= wr_data[4:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      term <= RESET_DEC[CW-1:0];
    end else if (clk_en) begin
      cnt  <= '0;
      term <= sel_dec[CW-1:0];
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

module mclk_divider_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       wr_unlock,
  input logic       lp_entry,
  input logic       osc_mode,
  input logic       dbl_speed,
  input logic       clk_en,
  input logic [7:0] rd_data,
  input logic       code_err
);
  logic [4:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap <= '0;
    else if (clk_en) gap <= '0;
    else             gap <= gap + 1'b1;
  end

  p_gap_bound_r3: assert property (@(posedge clk) disable iff (!rst_n) gap < 5'd16);

  p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4:0] inside {5'b10010, 5'b00010, 5'b00011, 5'b00100, 5'b00110,
                         5'b01000, 5'b01010, 5'b01100, 5'b01110, 5'b00000});

  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n) rd_data[7:5] == 3'b000);

  p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_unlock && !(lp_entry && !osc_mode)) |=> $stable(rd_data));

  p_dbl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_speed && !(lp_entry && !osc_mode)) |=> $stable(rd_data));

  p_lp_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_entry && !osc_mode) |=> rd_data == 8'h08);

  p_err_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> $past(wr_en && wr_unlock && !dbl_speed));
endmodule

bind mclk_divider mclk_divider_chk chk_i (.*);

// File: tb/mclk_divider_tb_top.sv
module mclk_divider_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_unlock = 0, lp_entry = 0, osc_mode = 0, dbl_speed = 0;
  logic [7:0] wr_data = 8'h00;
  logic clk_en, code_err;
  logic [7:0] rd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mclk_divider dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_unlock(wr_unlock), .lp_entry(lp_entry), .osc_mode(osc_mode),
    .dbl_speed(dbl_speed), .clk_en(clk_en), .rd_data(rd_data), .code_err(code_err));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one write cycle; on return (negedge) register and code_err are updated
  task automatic do_write(input logic [7:0] d, input logic unl);
    wr_data = d; wr_unlock = unl; wr_en = 1;
    @(negedge clk);
    wr_en = 0; wr_unlock = 0;
  endtask

  // cycles until next clk_en seen at a negedge
  task automatic next_pulse(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!clk_en && n < 100);
  endtask

  task automatic t_reset;
    int g;
    chk("R1 reset readback", rd_data, 8'h08);
    next_pulse(g);
    next_pulse(g);
    chk("R1 reset ratio 8", g, 8);
  endtask

  task automatic t_all_codes;
    logic [4:0] codes [10] = '{5'b10010, 5'b00010, 5'b00011, 5'b00100, 5'b00110,
                               5'b01000, 5'b01010, 5'b01100, 5'b01110, 5'b00000};
    int ratios [10] = '{1, 2, 3, 4, 6, 8, 10, 12, 14, 16};
    for (int i = 0; i < 10; i++) begin
      int g, cnt, hi;
      do_write({3'b000, codes[i]}, 1'b1);
      chk("R2 readback", rd_data, {3'b000, codes[i]});
      next_pulse(g);
      cnt = 0; hi = 1;
      for (int k = 0; k < 1680; k++) begin
        @(negedge clk);
        if (clk_en) cnt++; else hi = 0;
      end
      chk("R3 pulse count", cnt, 1680 / ratios[i]);
      if (ratios[i] == 1) chk("R3 constant high at ratio 1", hi, 1);
    end
  endtask

  task automatic t_protect;
    do_write(8'h04, 1'b1);
    do_write(8'h0C, 1'b0);
    chk("R4 locked write ignored", rd_data, 8'h04);
    chk("R6 no error on locked write", code_err, 0);
  endtask

  task automatic t_dbl;
    dbl_speed = 1;
    do_write(8'h02, 1'b1);
    chk("R5 write ignored in double speed", rd_data, 8'h04);
    chk("R6 no error on frozen write", code_err, 0);
    dbl_speed = 0;
  endtask

  task automatic t_illegal;
    do_write(8'h01, 1'b1);
    chk("R6 illegal code rejected", rd_data, 8'h04);
    chk("R6 error pulse", code_err, 1);
    @(negedge clk);
    chk("R6 error lasts one cycle", code_err, 0);
    do_write(8'h06, 1'b1);
    chk("R6 no error on legal write", code_err, 0);
  endtask

  task automatic t_reserved;
    do_write(8'hE4, 1'b1);
    chk("R10 upper write bits ignored", rd_data, 8'h04);
  endtask

  task automatic t_lp;
    int g;
    do_write(8'h00, 1'b1);
    lp_entry = 1; @(negedge clk); lp_entry = 0;
    chk("R7 forced reload", rd_data, 8'h08);
    next_pulse(g);
    next_pulse(g);
    chk("R7 ratio after reload", g, 8);
  endtask

  task automatic t_osc;
    do_write(8'h03, 1'b1);
    osc_mode = 1; lp_entry = 1; @(negedge clk); lp_entry = 0;
    chk("R8 oscillator mode exempt", rd_data, 8'h03);
    osc_mode = 0;
  endtask

  task automatic t_priority;
    do_write(8'h0E, 1'b1);
    lp_entry = 1;
    do_write(8'h02, 1'b1);
    lp_entry = 0;
    chk("R11 reload beats write", rd_data, 8'h08);
  endtask

  task automatic t_boundary;
    int g;
    do_write(8'h08, 1'b1);
    next_pulse(g);
    next_pulse(g);
    repeat (3) @(negedge clk);
    do_write(8'h02, 1'b1);
    next_pulse(g);
    chk("R9 old period kept", g + 4, 8);
    next_pulse(g);
    chk("R9 new ratio next period", g, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_all_codes();
    t_protect();
    t_dbl();
    t_illegal();
    t_reserved();
    t_lp();
    t_osc();
    t_priority();
    t_boundary();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule